// File: doc/BRIEF.md
# Transmit Descriptor Command Qualifier

This block sits behind the descriptor fetch logic of a transmit path. Data descriptors reach it in order, one per cycle at most, each carrying a command byte, a buffer length, a 16-bit special field (the VLAN tag value) and a payload total. The block finds where each packet or segmentation context starts and ends. It decides which descriptor supplies the per-packet offload choices and resolves those choices into one option set per packet. The option set says whether a VLAN tag is inserted, whether the frame check sequence is appended, and which tag value is used.

The block has two modes. In a segmentation context, the options come from the opening descriptor. The block also tracks how much payload is still outstanding and checks the closing descriptor's length against it. A mismatch ends the context and adds one to a saturating failure counter. In a normal packet, the options come only from the closing (end-of-packet) descriptor. A device-wide VLAN enable input can veto tag insertion. A command byte that is not a well-formed data descriptor raises a one-cycle error pulse, but the descriptor is still consumed and tracked.

Top module: `txd_cmd_qualifier`

## Requirements
- R1: After a synchronous reset, `opt_valid`, `pkt_sop`, `pkt_eop` and `cmd_err` are low and `fail_cnt` is zero.
- R2: Command byte layout: bit 0 end-of-packet, bit 1 FCS insert, bit 2 segmentation, bit 3 report-status, bit 4 reserved, bit 5 extended-descriptor, bit 6 VLAN insert, bit 7 interrupt-delay. If an accepted descriptor has bit 5 clear or bit 4 set, `cmd_err` pulses high for exactly the next cycle, and the descriptor is still tracked as usual.
- R3: `pkt_sop` pulses the cycle after the first descriptor of a packet or context is accepted. `pkt_eop` pulses the cycle after a descriptor with bit 0 set is accepted.
- R4: In normal mode, `opt_valid` pulses the cycle after the end-of-packet descriptor. Options come only from that descriptor; the option bits and tags of earlier descriptors have no effect.
- R5: In segmentation mode, `opt_valid` pulses the cycle after the first descriptor. Options come from that descriptor; later descriptors' option bits and tags have no effect.
- R6: Option resolution: `opt_vlan_ins` = bit 6 AND `vlan_global_en` (sampled with the qualifying descriptor). `opt_fcs_ins` = bit 1 OR `opt_vlan_ins`. `opt_tag` = that descriptor's special field.
- R7: The mode of a packet is set by bit 2 of its first descriptor; bit 2 of later descriptors is ignored. `opt_seg` reports the mode with `opt_valid`.
- R8: In segmentation mode, the end-of-packet descriptor's length must equal the payload total (taken from the first descriptor) minus the lengths of all earlier descriptors of the context. On a mismatch, `fail_cnt` increments one cycle later. The context ends either way.
- R9: `fail_cnt` saturates at all-ones and does not wrap.
- R10: `fail_clr` zeroes `fail_cnt` on the next cycle and takes priority over a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor present this cycle |
| desc_cmd | input | 8 | Command byte |
| desc_len | input | LEN_W | Buffer length of this descriptor |
| desc_special | input | TAG_W | VLAN tag value |
| desc_paylen | input | PAY_W | Segmentation payload total (used on first descriptor) |
| vlan_global_en | input | 1 | Device-wide VLAN insertion enable |
| fail_clr | input | 1 | Synchronous clear of the failure counter |
| opt_valid | output | 1 | Resolved option set present |
| opt_seg | output | 1 | Packet is a segmentation context |
| opt_vlan_ins | output | 1 | Insert VLAN tag |
| opt_fcs_ins | output | 1 | Append frame check sequence |
| opt_tag | output | TAG_W | Tag value to insert |
| pkt_sop | output | 1 | Start-of-packet marker |
| pkt_eop | output | 1 | End-of-packet marker |
| cmd_err | output | 1 | Malformed command byte pulse |
| fail_cnt | output | CNT_W | Saturating length-mismatch count |

## Verification
The bench keeps the default length, payload and tag widths but builds the block with a 4-bit failure counter. With that setting, saturation and the no-wrap rule can be reached after sixteen mismatching single-descriptor contexts, where a 32-bit counter would never get there. The payload width of 20 bits lets multi-descriptor contexts of several hundred bytes run without any wrap of the remaining count, so every mismatch the bench sees is one it created on purpose.

// File: rtl/txd_cmd_pkg.sv
package txd_cmd_pkg;
  // Command byte bit positions
  localparam int unsigned BIT_EOP  = 0;
  localparam int unsigned BIT_FCS  = 1;
  localparam int unsigned BIT_SEG  = 2;
  localparam int unsigned BIT_RPT  = 3;
  localparam int unsigned BIT_RSV  = 4;
  localparam int unsigned BIT_EXT  = 5;
  localparam int unsigned BIT_VLAN = 6;
  localparam int unsigned BIT_IDLY = 7;
  localparam int unsigned CMD_W    = 8;

  // Bits that must read zero in a well-formed command byte
  localparam logic [CMD_W-1:0] RSV_MASK = CMD_W'(1) << BIT_RSV;

  typedef struct packed {
    logic vlan;
    logic seg;
    logic fcs;
    logic eop;
  } cmd_flags_t;
endpackage

// File: rtl/txd_cmd_decode.sv
module txd_cmd_decode
  import txd_cmd_pkg::*;
#(
  parameter logic [CMD_W-1:0] RESERVED = RSV_MASK
) (
  input  logic [CMD_W-1:0] cmd_byte,
  output cmd_flags_t       flags,
  output logic             malformed
);
  logic [CMD_W-1:0] rsv_hit;

  // One probe per command bit; only masked positions can flag an error
  for (genvar i = 0; i < CMD_W; i++) begin : g_rsv
    assign rsv_hit[i] = cmd_byte[i] & RESERVED[i];
  end

  always_comb begin
    flags.eop  = cmd_byte[BIT_EOP];
    flags.fcs  = cmd_byte[BIT_FCS];
    flags.seg  = cmd_byte[BIT_SEG];
    flags.vlan = cmd_byte[BIT_VLAN];
    malformed  = ~cmd_byte[BIT_EXT] | (|rsv_hit);
  end
endmodule

// File: rtl/txd_ctx_track.sv
module txd_ctx_track #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned PAY_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             eop,
  input  logic             seg_req,
  input  logic [LEN_W-1:0] len,
  input  logic [PAY_W-1:0] paylen,
  output logic             first,
  output logic             mode_seg,
  output logic             mismatch
);
  logic             in_pkt_q;
  logic             seg_q;
  logic [PAY_W-1:0] rem_q;
  logic [PAY_W-1:0] len_ext;
  logic [PAY_W-1:0] owed;

  always_comb begin
    len_ext  = PAY_W'(len);
    first    = ~in_pkt_q;
    mode_seg = first ? seg_req : seg_q;
    owed     = first ? paylen : rem_q;
    mismatch = take & eop & mode_seg & (len_ext != owed);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt_q <= 1'b0;
      seg_q    <= 1'b0;
      rem_q    <= '0;
    end else if (take) begin
      in_pkt_q <= ~eop;
      seg_q    <= mode_seg;
      rem_q    <= owed - len_ext;
    end
  end
endmodule

// File: rtl/txd_fail_ctr.sv
module txd_fail_ctr #(
  parameter int unsigned CNT_W    = 32,
  parameter bit          SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic bump;

  if (SATURATE) begin : g_sat
    assign bump = inc & (cnt != TOP);
  end else begin : g_wrap
    assign bump = inc;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bump)  cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/txd_cmd_qualifier.sv
module txd_cmd_qualifier
  import txd_cmd_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned PAY_W = 20,
  parameter int unsigned TAG_W = 16,
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             desc_valid,
  input  logic [7:0]       desc_cmd,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [TAG_W-1:0] desc_special,
  input  logic [PAY_W-1:0] desc_paylen,
  input  logic             vlan_global_en,
  input  logic             fail_clr,
  output logic             opt_valid,
  output logic             opt_seg,
  output logic             opt_vlan_ins,
  output logic             opt_fcs_ins,
  output logic [TAG_W-1:0] opt_tag,
  output logic             pkt_sop,
  output logic             pkt_eop,
  output logic             cmd_err,
  output logic [CNT_W-1:0] fail_cnt
);
  cmd_flags_t flags;
  logic       malformed;
  logic       first;
  logic       mode_seg;
  logic       mismatch;
  logic       qualify;
  logic       vlan_eff;

  txd_cmd_decode u_decode (
    .cmd_byte  (desc_cmd),
    .flags     (flags),
    .malformed (malformed)
  );

  txd_ctx_track #(.LEN_W(LEN_W), .PAY_W(PAY_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .take     (desc_valid),
    .eop      (flags.eop),
    .seg_req  (flags.seg),
    .len      (desc_len),
    .paylen   (desc_paylen),
    .first    (first),
    .mode_seg (mode_seg),
    .mismatch (mismatch)
  );

  txd_fail_ctr #(.CNT_W(CNT_W), .SATURATE(1'b1)) u_fail (
    .clk (clk),
    .rst (rst),
    .clr (fail_clr),
    .inc (mismatch),
    .cnt (fail_cnt)
  );

  // Options come from the opening descriptor of a context or the closing one of a plain packet
  always_comb begin
    qualify  = desc_valid & (mode_seg ? first : flags.eop);
    vlan_eff = flags.vlan & vlan_global_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_valid    <= 1'b0;
      opt_seg      <= 1'b0;
      opt_vlan_ins <= 1'b0;
      opt_fcs_ins  <= 1'b0;
      opt_tag      <= '0;
      pkt_sop      <= 1'b0;
      pkt_eop      <= 1'b0;
      cmd_err      <= 1'b0;
    end else begin
      opt_valid <= qualify;
      pkt_sop   <= desc_valid & first;
      pkt_eop   <= desc_valid & flags.eop;
      cmd_err   <= desc_valid & malformed;
      if (qualify) begin
        opt_seg      <= mode_seg;
        opt_vlan_ins <= vlan_eff;
        opt_fcs_ins  <= flags.fcs | vlan_eff;
        opt_tag      <= desc_special;
      end
    end
  end
endmodule

// File: rtl/txd_cmd_qualifier_chk.sv
module txd_cmd_qualifier_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_valid,
  input logic [7:0]       desc_cmd,
  input logic             fail_clr,
  input logic             opt_valid,
  input logic             opt_vlan_ins,
  input logic             opt_fcs_ins,
  input logic             pkt_eop,
  input logic             cmd_err,
  input logic [CNT_W-1:0] fail_cnt
);
  a_r2_bad_cmd_pulse: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && (!desc_cmd[5] || desc_cmd[4])) |=> cmd_err);

  a_r2_no_spurious_err: assert property (@(posedge clk) disable iff (rst)
    !desc_valid |=> !cmd_err);

  a_r3_eop_marker: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_cmd[0]) |=> pkt_eop);

  a_r6_vlan_implies_fcs: assert property (@(posedge clk) disable iff (rst)
    (opt_valid && opt_vlan_ins) |-> opt_fcs_ins);

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    !fail_clr |=> fail_cnt >= $past(fail_cnt));

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    fail_clr |=> fail_cnt == '0);
endmodule

bind txd_cmd_qualifier txd_cmd_qualifier_chk #(.CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .desc_valid   (desc_valid),
  .desc_cmd     (desc_cmd),
  .fail_clr     (fail_clr),
  .opt_valid    (opt_valid),
  .opt_vlan_ins (opt_vlan_ins),
  .opt_fcs_ins  (opt_fcs_ins),
  .pkt_eop      (pkt_eop),
  .cmd_err      (cmd_err),
  .fail_cnt     (fail_cnt)
);

// File: tb/txd_cmd_qualifier_tb_top.sv
`timescale 1ns/1ps
module txd_cmd_qualifier_tb_top;
  localparam int LEN_W = 16;
  localparam int PAY_W = 20;
  localparam int TAG_W = 16;
  localparam int CNT_W = 4;
  localparam int EXP_W = 4 + TAG_W + 3 + CNT_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             desc_valid = 1'b0;
  logic [7:0]       desc_cmd = '0;
  logic [LEN_W-1:0] desc_len = '0;
  logic [TAG_W-1:0] desc_special = '0;
  logic [PAY_W-1:0] desc_paylen = '0;
  logic             vlan_global_en = 1'b0;
  logic             fail_clr = 1'b0;
  logic             opt_valid, opt_seg, opt_vlan_ins, opt_fcs_ins;
  logic [TAG_W-1:0] opt_tag;
  logic             pkt_sop, pkt_eop, cmd_err;
  logic [CNT_W-1:0] fail_cnt;

  always #10 clk = ~clk;

  txd_cmd_qualifier #(.LEN_W(LEN_W), .PAY_W(PAY_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_cmd(desc_cmd),
    .desc_len(desc_len), .desc_special(desc_special), .desc_paylen(desc_paylen),
    .vlan_global_en(vlan_global_en), .fail_clr(fail_clr),
    .opt_valid(opt_valid), .opt_seg(opt_seg), .opt_vlan_ins(opt_vlan_ins),
    .opt_fcs_ins(opt_fcs_ins), .opt_tag(opt_tag), .pkt_sop(pkt_sop),
    .pkt_eop(pkt_eop), .cmd_err(cmd_err), .fail_cnt(fail_cnt)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [EXP_W-1:0] exp_q[$];
  string            req_q[$];

  // Reference state, derived from the requirements
  logic             m_in = 1'b0;
  logic             m_seg = 1'b0;
  logic [PAY_W-1:0] m_rem = '0;
  logic [CNT_W-1:0] m_cnt = '0;
  logic             ev_d = 1'b0;

  always @(posedge clk) ev_d <= !rst && (desc_valid || fail_clr);

  function automatic logic [EXP_W-1:0] pack_out(
      input logic ov, sg, vl, fc, input logic [TAG_W-1:0] tg,
      input logic sp, ep, er, input logic [CNT_W-1:0] ct);
    logic o_sg = ov & sg;
    logic o_vl = ov & vl;
    logic o_fc = ov & fc;
    logic [TAG_W-1:0] o_tg = (ov & vl) ? tg : '0;
    return {ov, o_sg, o_vl, o_fc, o_tg, sp, ep, er, ct};
  endfunction

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (ev_d) begin
      logic [EXP_W-1:0] got;
      logic [EXP_W-1:0] want;
      string r;
      got = pack_out(opt_valid, opt_seg, opt_vlan_ins, opt_fcs_ins, opt_tag,
                     pkt_sop, pkt_eop, cmd_err, fail_cnt);
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard: output event with empty queue, actual %h expected none", got);
      end else begin
        want = exp_q.pop_front();
        r = req_q.pop_front();
        n_vec++;
        if (got !== want) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", r, got, want);
        end
      end
    end else if (!rst) begin
      if (opt_valid || pkt_sop || pkt_eop || cmd_err) begin
        n_vec++; n_bad++;
        $display("FAIL R3: pulse outside event, actual %b%b%b%b expected 0000",
                 opt_valid, pkt_sop, pkt_eop, cmd_err);
      end
    end
  end

  task automatic send(input logic [7:0] cmd, input int len, input logic [TAG_W-1:0] tag,
                      input int pay, input logic glob, input logic clr, input string req);
    logic first = !m_in;
    logic mseg = first ? cmd[2] : m_seg;
    logic [PAY_W-1:0] owed = first ? PAY_W'(pay) : m_rem;
    logic mism = cmd[0] & mseg & (PAY_W'(len) != owed);
    logic qual = mseg ? first : cmd[0];
    logic vl = cmd[6] & glob;
    logic fc = cmd[1] | vl;
    logic er = !cmd[5] | cmd[4];
    if (clr) m_cnt = '0;
    else if (mism && m_cnt != '1) m_cnt = m_cnt + 1'b1;
    m_in = !cmd[0];
    m_seg = mseg;
    m_rem = owed - PAY_W'(len);
    @(negedge clk);
    exp_q.push_back(pack_out(qual, mseg, vl, fc, tag, first, cmd[0], er, m_cnt));
    req_q.push_back(req);
    desc_valid = 1'b1; desc_cmd = cmd; desc_len = LEN_W'(len);
    desc_special = tag; desc_paylen = PAY_W'(pay); vlan_global_en = glob; fail_clr = clr;
    @(negedge clk);
    desc_valid = 1'b0; fail_clr = 1'b0; desc_cmd = '0;
  endtask

  task automatic clear_only(input string req);
    m_cnt = '0;
    @(negedge clk);
    exp_q.push_back(pack_out(1'b0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0));
    req_q.push_back(req);
    fail_clr = 1'b1;
    @(negedge clk);
    fail_clr = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: reset state
    n_vec++;
    if (opt_valid || pkt_sop || pkt_eop || cmd_err || fail_cnt != 0) begin
      n_bad++;
      $display("FAIL R1: actual %b%b%b%b cnt %0d expected 0000 cnt 0",
               opt_valid, pkt_sop, pkt_eop, cmd_err, fail_cnt);
    end

    // R4 R6: single-descriptor normal packet with VLAN
    send(8'h61, 64, 16'hABCD, 0, 1'b1, 1'b0, "R6 vlan+forced fcs");
    // R4: earlier descriptors' options ignored, last one clean
    send(8'h62, 100, 16'h1111, 0, 1'b1, 1'b0, "R4 mid desc");
    send(8'h62, 100, 16'h2222, 0, 1'b1, 1'b0, "R4 mid desc");
    send(8'h21, 50, 16'h3333, 0, 1'b1, 1'b0, "R4 eop supplies options");
    // R6: global veto, fcs from bit 1
    send(8'h61, 40, 16'h4444, 0, 1'b0, 1'b0, "R6 global veto");
    send(8'h23, 40, 16'h5555, 0, 1'b0, 1'b0, "R6 fcs only");
    // R7: segmentation bit on a later descriptor of a normal packet ignored
    send(8'h20, 10, 16'h0, 0, 1'b1, 1'b0, "R7 normal first");
    send(8'h24, 10, 16'h0, 0, 1'b1, 1'b0, "R7 later seg bit ignored");
    send(8'h61, 10, 16'h6666, 0, 1'b1, 1'b0, "R7 normal close");

    // R5 R8: good three-descriptor segmentation context
    send(8'h64, 100, 16'h1234, 300, 1'b1, 1'b0, "R5 seg first");
    send(8'h22, 100, 16'h9999, 0, 1'b1, 1'b0, "R5 seg middle");
    send(8'h61, 100, 16'h8888, 0, 1'b1, 1'b0, "R8 seg close match");
    // R8: mismatch on close
    send(8'h26, 100, 16'h0042, 300, 1'b0, 1'b0, "R5 seg first no vlan");
    send(8'h21, 150, 16'h0, 0, 1'b1, 1'b0, "R8 seg close mismatch");
    // R8: single-descriptor contexts, match and mismatch
    send(8'h65, 64, 16'h0777, 64, 1'b1, 1'b0, "R8 single match");
    send(8'h25, 60, 16'h0, 64, 1'b1, 1'b0, "R8 single mismatch");
    // R3: context ended after mismatch, next starts fresh
    send(8'h21, 20, 16'h0, 0, 1'b1, 1'b0, "R3 fresh packet after fail");

    // R2: malformed command bytes still tracked
    send(8'h01, 20, 16'h0, 0, 1'b1, 1'b0, "R2 ext clear");
    send(8'h30, 20, 16'h0, 0, 1'b1, 1'b0, "R2 reserved set");
    send(8'h21, 20, 16'h0, 0, 1'b1, 1'b0, "R2 tracking continued");
    send(8'hA9, 20, 16'h0, 0, 1'b1, 1'b0, "R2 bits 3 and 7 harmless");

    // R10: clear alone, then clear against a mismatch
    clear_only("R10 clear");
    send(8'h25, 5, 16'h0, 9, 1'b1, 1'b0, "R8 mismatch before clear");
    send(8'h25, 5, 16'h0, 9, 1'b1, 1'b1, "R10 clear beats increment");

    // R9: saturation
    for (int i = 0; i < 17; i++)
      send(8'h25, 10, 16'h0, 20, 1'b1, 1'b0, "R9 saturate");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule